// File: doc/BRIEF.md
# Shadow Program Memory Switcher

This block is the memory decoder of a small 8-bit controller whose program sits in a slow ROM. At start-up the firmware copies the ROM into a fast 64K x 8 SRAM, and the SRAM then becomes the program memory. While the copy runs, reads and fetches in the 16-bit code space select the ROM, and every CPU write selects the SRAM with its write enable. Software can therefore read from the ROM and write the same address into the SRAM. The copy can start at a parameter offset (`COPY_BASE`), so the low region that holds the copy loop itself is not overwritten while it runs.

A write to the all-ones address ends the copy. From the next cycle the block is locked. Reads and fetches go to the SRAM, plain writes are dropped, and the ROM is switched off. One exception applies when `KEEP_LOW_ROM` is set. In that case, fetches below `COPY_BASE` keep coming from the ROM until the first locked fetch at or above `COPY_BASE`. This keeps the copy routine reachable until it jumps into the shadowed code. A patch input re-opens SRAM writes while the block is locked. Only reset clears the lock.

Top module: `shadow_mem_switch`

## Requirements
- R1: While reset is asserted and right after it is released, `stat_locked` and `stat_patch` are 0, and a fetch drives `rom_ce`=1 and `ram_ce`=0.
- R2: Before lock, any write (`wr`=1) drives `ram_ce`=1, `ram_we`=1 and `rom_ce`=0, at every address.
- R3: Before lock, a fetch or data read without `wr` drives `rom_ce`=1, `ram_ce`=0 and `ram_we`=0. `patch_en` has no effect before lock, and `stat_patch` stays 0.
- R4: A write to address 0xFFFF before lock is itself a normal SRAM write (`ram_ce`=1, `ram_we`=1). `stat_locked` goes to 1 from the next cycle.
- R5: When locked, data reads at any address, and fetches at or above `COPY_BASE`, drive `ram_ce`=1, `rom_ce`=0 and `ram_we`=0.
- R6: When locked with `patch_en`=0, a write is ignored: `ram_ce`, `ram_we` and `rom_ce` are all 0.
- R7: When locked with `patch_en`=1, a write drives `ram_ce`=1 and `ram_we`=1, and `stat_patch` is 1.
- R8: When locked and `KEEP_LOW_ROM`=1, a fetch below `COPY_BASE` drives `rom_ce`=1 until the first locked fetch (without `wr`) at or above `COPY_BASE`. From the cycle after that fetch, every fetch uses the SRAM and `rom_ce` stays 0 for every access.
- R9: A write strobe together with a read or fetch strobe is decoded as a write alone. With no strobe active, all enables are 0.
- R10: `rom_ce` and `ram_ce` are never 1 in the same cycle.
- R11: Once set, the lock stays set through any access pattern until reset. After reset, the block is back in ROM-fetch, SRAM-write mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 16 | CPU address |
| fetch | input | 1 | Program fetch strobe, active high |
| rd | input | 1 | Data read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| patch_en | input | 1 | Port bit that re-enables SRAM writes after lock |
| rom_ce | output | 1 | ROM chip enable, active high |
| ram_ce | output | 1 | SRAM chip enable, active high |
| ram_we | output | 1 | SRAM write enable, active high |
| stat_locked | output | 1 | Lock flag |
| stat_patch | output | 1 | Patch writes currently active |

## Verification
The bench sweeps all eight combinations of the three strobes across an address list. The list holds 64 spread addresses plus the cells on both sides of `COPY_BASE` and the top two addresses. This sweep runs in the unlocked phase, in the locked phase with patch off and in the locked phase with patch on. The phases distinguish the ROM-read/SRAM-write split, dropped writes and patch writes. The strobe combinations show that write wins over reads. Separate directed steps place fetches below and at `COPY_BASE` around the first high fetch. These steps distinguish the low ROM window from a ROM that is switched off at once. They also check that the handover write itself lands in the SRAM one cycle before the lock shows.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE,
    ACC_READ,
    ACC_FETCH,
    ACC_WRITE
  } acc_t;

  typedef struct packed {
    logic rom_ce;
    logic ram_ce;
    logic ram_we;
  } mem_sel_t;

endpackage

// File: rtl/shadow_rst_sync.sv
module shadow_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/shadow_lock_ctrl.sv
module shadow_lock_ctrl
  import shadow_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned COPY_BASE = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_t              acc,
  input  logic [ADDR_W-1:0] addr,
  output logic              lock_q,
  output logic              passed_q
);

  localparam logic [ADDR_W-1:0] TOP_A  = '1;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(COPY_BASE);

  logic lock_d, lock_en;
  logic passed_d, passed_en;

  // next-state logic
  always_comb begin
    lock_en   = !lock_q && (acc == ACC_WRITE) && (addr == TOP_A);
    lock_d    = 1'b1;
    passed_en = lock_q && !passed_q && (acc == ACC_FETCH) && (addr >= BASE_A);
    passed_d  = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      passed_q <= 1'b0;
    end else begin
      if (lock_en)   lock_q   <= lock_d;
      if (passed_en) passed_q <= passed_d;
    end
  end

endmodule

// File: rtl/shadow_route.sv
module shadow_route
  import shadow_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned COPY_BASE    = 'h100,
  parameter bit          KEEP_LOW_ROM = 1'b1
) (
  input  acc_t              acc,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lock,
  input  logic              passed,
  input  logic              patch_en,
  output mem_sel_t          sel
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(COPY_BASE);

  logic low_rom_window;

  generate
    if (KEEP_LOW_ROM) begin : g_low_rom
      assign low_rom_window = !passed && (addr < BASE_A);
    end else begin : g_no_low_rom
      assign low_rom_window = 1'b0;
    end
  endgenerate

  always_comb begin
    sel = '0;
    unique case (acc)
      ACC_WRITE: begin
        if (!lock || patch_en) begin
          sel.ram_ce = 1'b1;
          sel.ram_we = 1'b1;
        end
      end
      ACC_READ: begin
        if (lock) sel.ram_ce = 1'b1;
        else      sel.rom_ce = 1'b1;
      end
      ACC_FETCH: begin
        if (!lock || low_rom_window) sel.rom_ce = 1'b1;
        else                         sel.ram_ce = 1'b1;
      end
      default: sel = '0;
    endcase
  end

endmodule

// File: rtl/shadow_mem_switch.sv
module shadow_mem_switch
  import shadow_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned COPY_BASE    = 'h100,
  parameter bit          KEEP_LOW_ROM = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              fetch,
  input  logic              rd,
  input  logic              wr,
  input  logic              patch_en,
  output logic              rom_ce,
  output logic              ram_ce,
  output logic              ram_we,
  output logic              stat_locked,
  output logic              stat_patch
);

  logic     rst_sync_n;
  logic     lock_q, passed_q;
  acc_t     acc;
  mem_sel_t sel;

  // write wins over any read strobe
  always_comb begin
    if (wr)         acc = ACC_WRITE;
    else if (fetch) acc = ACC_FETCH;
    else if (rd)    acc = ACC_READ;
    else            acc = ACC_IDLE;
  end

  shadow_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  shadow_lock_ctrl #(
    .ADDR_W    (ADDR_W),
    .COPY_BASE (COPY_BASE)
  ) i_lock (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .acc      (acc),
    .addr     (addr),
    .lock_q   (lock_q),
    .passed_q (passed_q)
  );

  shadow_route #(
    .ADDR_W       (ADDR_W),
    .COPY_BASE    (COPY_BASE),
    .KEEP_LOW_ROM (KEEP_LOW_ROM)
  ) i_route (
    .acc      (acc),
    .addr     (addr),
    .lock     (lock_q),
    .passed   (passed_q),
    .patch_en (patch_en),
    .sel      (sel)
  );

  assign rom_ce      = sel.rom_ce;
  assign ram_ce      = sel.ram_ce;
  assign ram_we      = sel.ram_we;
  assign stat_locked = lock_q;
  assign stat_patch  = lock_q && patch_en;

endmodule

// File: rtl/shadow_mem_switch_chk.sv
module shadow_mem_switch_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [ADDR_W-1:0] addr,
  input logic              fetch,
  input logic              rd,
  input logic              wr,
  input logic              patch_en,
  input logic              rom_ce,
  input logic              ram_ce,
  input logic              ram_we,
  input logic              stat_locked,
  input logic              passed_q
);

  AST_CE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(rom_ce && ram_ce)); // R10

  AST_LOCK_ON_TOP_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr && (addr == '1)) |=> stat_locked); // R4

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stat_locked |=> stat_locked); // R11

  AST_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stat_locked && !patch_en) |-> (!ram_we && !ram_ce && !rom_ce) || !wr); // R6

  AST_PATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stat_locked && patch_en && wr) |-> (ram_we && ram_ce)); // R7

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr |-> !rom_ce); // R9

  AST_ROM_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    passed_q |-> !rom_ce); // R8

  AST_UNLOCKED_READ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!stat_locked && !wr && (fetch || rd)) |-> (rom_ce && !ram_we)); // R3

endmodule

bind shadow_mem_switch shadow_mem_switch_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .addr        (addr),
  .fetch       (fetch),
  .rd          (rd),
  .wr          (wr),
  .patch_en    (patch_en),
  .rom_ce      (rom_ce),
  .ram_ce      (ram_ce),
  .ram_we      (ram_we),
  .stat_locked (stat_locked),
  .passed_q    (passed_q)
);

// File: tb/test_shadow_mem_switch.sv
`timescale 1ns/1ps
module test_shadow_mem_switch;

  localparam int unsigned BASE = 'h100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        fetch = 1'b0, rd = 1'b0, wr = 1'b0, patch_en = 1'b0;
  logic        rom_ce, ram_ce, ram_we, stat_locked, stat_patch;

  int total = 0;
  int bad = 0;

  // bench-side model state
  bit m_lock = 1'b0;
  bit m_pass = 1'b0;

  always #10 clk = ~clk;

  shadow_mem_switch #(.ADDR_W(16), .COPY_BASE(BASE), .KEEP_LOW_ROM(1'b1)) i_shadow_mem_switch (
    .clk(clk), .rst_n(rst_n), .addr(addr), .fetch(fetch), .rd(rd), .wr(wr),
    .patch_en(patch_en), .rom_ce(rom_ce), .ram_ce(ram_ce), .ram_we(ram_we),
    .stat_locked(stat_locked), .stat_patch(stat_patch)
  );

  function automatic logic [2:0] expect_sel(bit lk, bit ps, bit pt, bit f, bit r, bit w, logic [15:0] a);
    if (w)      return (!lk || pt) ? 3'b011 : 3'b000;         // R2 R6 R7 R9
    if (f) begin
      if (!lk)                       return 3'b100;          // R3
      if (!ps && (a < 16'(BASE)))    return 3'b100;          // R8
      return 3'b010;                                         // R5
    end
    if (r)      return lk ? 3'b010 : 3'b100;                 // R3 R5
    return 3'b000;                                           // R9
  endfunction

  task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: addr=%h f/r/w=%b%b%b got {rom,ram,we,lock,patch}=%b expected %b",
               req, addr, fetch, rd, wr, act, exp);
    end
  endtask

  function automatic string tag_for(bit lk, bit pt, bit w);
    if (!lk) return w ? "R2" : "R3";
    if (w)   return pt ? "R7" : "R6";
    return "R5";
  endfunction

  task automatic apply(logic [15:0] a, bit f, bit r, bit w, string req);
    logic [2:0] e;
    @(negedge clk);
    addr = a; fetch = f; rd = r; wr = w;
    #2;
    e = expect_sel(m_lock, m_pass, patch_en, f, r, w, a);
    chk(req, {rom_ce, ram_ce, ram_we, stat_locked, stat_patch},
        {e, m_lock, m_lock & patch_en});
    if (m_lock && f && !w && (a >= 16'(BASE))) m_pass = 1'b1;
    if (!m_lock && w && (a == 16'hFFFF))       m_lock = 1'b1;
  endtask

  task automatic idle();
    @(negedge clk);
    fetch = 0; rd = 0; wr = 0;
  endtask

  function automatic logic [15:0] addr_at(int i);
    case (i)
      64: return 16'(BASE - 1);
      65: return 16'(BASE);
      66: return 16'hFFFE;
      67: return 16'hFFFF;
      default: return 16'(i * 'h0411);
    endcase
  endfunction

  task automatic sweep(bit allow_top_write);
    for (int i = 0; i < 68; i++) begin
      for (int s = 0; s < 8; s++) begin
        logic [15:0] a;
        a = addr_at(i);
        if (!allow_top_write && s[2] && a == 16'hFFFF) continue;
        apply(a, s[0], s[1], s[2], tag_for(m_lock, patch_en, s[2]));
      end
    end
    idle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; fetch = 1; rd = 0; wr = 0; addr = 16'h0040;
    m_lock = 0; m_pass = 0;
    repeat (2) @(negedge clk);
    #2;
    chk("R1 in reset", {rom_ce, ram_ce, ram_we, stat_locked, stat_patch}, 5'b10000);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 after release", {rom_ce, ram_ce, ram_we, stat_locked, stat_patch}, 5'b10000);
    fetch = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, got running expected done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();

    // unlocked sweep, patch off then on (patch must be inert: R3)
    patch_en = 0; sweep(1'b0);
    patch_en = 1; sweep(1'b0);
    patch_en = 0;

    // handover write R4
    apply(16'hFFFF, 0, 0, 1, "R4 top write");
    idle(); #2;
    chk("R4 lock next cycle", {rom_ce, ram_ce, ram_we, stat_locked, stat_patch}, 5'b00010);

    // low ROM window R8
    apply(16'h0010, 1, 0, 0, "R8 low fetch before pass");
    apply(16'(BASE - 1), 1, 0, 0, "R8 edge fetch before pass");
    apply(16'h0010, 0, 1, 0, "R5 low data read");
    apply(16'h0010, 1, 0, 1, "R9 fetch+write no pass");
    apply(16'(BASE), 1, 0, 0, "R8 first high fetch");
    apply(16'h0010, 1, 0, 0, "R8 low fetch after pass");
    apply(16'h0000, 1, 0, 0, "R8 zero fetch after pass");

    // locked sweeps R5 R6 R7 R10 R11
    patch_en = 0; sweep(1'b1);
    patch_en = 1; sweep(1'b1);
    patch_en = 0;
    apply(16'hFFFF, 0, 0, 1, "R11 top write again");
    idle(); #2;
    chk("R11 lock kept", {rom_ce, ram_ce, ram_we, stat_locked, stat_patch}, 5'b00010);

    // only reset clears the lock
    do_reset();
    apply(16'h1234, 1, 0, 0, "R11 rom fetch after reset");
    apply(16'h1234, 0, 0, 1, "R11 ram write after reset");
    idle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule